// File: doc/BRIEF.md
# Cache Control Register with Interrupt Freeze

A 32-bit control and status register that a processor reads and writes through a plain register port. It holds one 2-bit operating state for the instruction cache and one for the data cache. It also holds a freeze-on-interrupt enable for each cache, an instruction burst-fetch enable, a data snoop enable, and two flush command bits that are never stored.

When the processor acknowledges an external interrupt, the block rewrites the two state fields on its own. Each cache that is currently enabled and has its freeze enable set moves to the frozen state, and the two caches are handled independently. A flush command produces a single-cycle request pulse toward the cache and raises a pending flag. That flag stays up until the cache reports completion.

The state fields are decoded into registered enable and frozen outputs for the cache controllers. The burst and snoop enables are also driven as outputs.

Top module: `cache_ctl_reg`

## Requirements
- R1: After synchronous reset, `rd_data` reads 0 and every output is low.
- R2: A write stores bits [1:0] (instruction state), [3:2] (data state), 4 (instruction freeze enable), 5 (data freeze enable), 16 (burst enable) and 23 (snoop enable). All other bits, including the flush command bits 21 and 22, read as 0 unless a pending flag is set.
- R3: A state value of 3 means enabled and 1 means frozen. `ic_enable`/`dc_enable` are high only for 3, and `ic_frozen`/`dc_frozen` only for 1. Values 0 and 2 drive both low. The outputs follow the stored state one clock after it changes.
- R4: On an acknowledge of an external interrupt, a cache whose state is 3 and whose freeze enable is 1 changes to state 1.
- R5: On that acknowledge, a state other than 3, or a cache whose freeze enable is 0, is left unchanged. Each cache follows only its own enable.
- R6: A trap number counts as external only when its bits above bit 3 equal those of the `EXT_BASE` parameter (default 0x10, so 0x10 to 0x1F). Any other acknowledged trap leaves both states unchanged.
- R7: Writing 1 to bit 21 (instruction) or bit 22 (data) drives `ic_flush_req`/`dc_flush_req` high for exactly the following cycle. It also sets pending bit 15 (instruction) or 14 (data).
- R8: A pending bit clears in the cycle after its flush-done input is high. Software writes to bits 14 and 15 have no effect.
- R9: If a write and an external acknowledge occur in the same cycle, the freeze rule is applied to the written state and freeze-enable values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| irq_trap | input | TRAP_W | Trap number being acknowledged |
| iflush_done | input | 1 | Instruction cache flush finished |
| dflush_done | input | 1 | Data cache flush finished |
| ic_enable | output | 1 | Instruction cache enabled |
| ic_frozen | output | 1 | Instruction cache frozen |
| dc_enable | output | 1 | Data cache enabled |
| dc_frozen | output | 1 | Data cache frozen |
| ic_flush_req | output | 1 | One-cycle instruction flush request |
| dc_flush_req | output | 1 | One-cycle data flush request |
| ic_burst | output | 1 | Instruction burst fetch enable |
| dc_snoop | output | 1 | Data snoop enable |

## Verification
The freeze logic is swept over every pair of state values and every pair of freeze enables. Each combination is tried with an external trap, with a non-external trap, and with a write landing in the same cycle as the acknowledge. This separates a freeze applied to the wrong cache, to a non-enabled state, or for the wrong trap class. It also shows whether a freeze acts on the old value or on the value written in that cycle. A separate flush sequence shows the pulse lasting one cycle, the pending flag outliving it, the done input clearing it, and software writes to the pending bits having no effect.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [1:0] {
    CST_OFF    = 2'd0,
    CST_FROZEN = 2'd1,
    CST_ON     = 2'd3
  } cache_st_e;

  localparam int NCACHE    = 2;   // index 0 = instruction, 1 = data
  localparam int FZ_LSB    = 4;   // freeze enables at 4 (I), 5 (D)
  localparam int FLUSH_LSB = 21;  // flush commands at 21 (I), 22 (D)
  localparam int PEND_I    = 15;
  localparam int PEND_D    = 14;
  localparam int BURST_BIT = 16;
  localparam int SNOOP_BIT = 23;
endpackage

// File: rtl/ccr_freeze.sv
module ccr_freeze
  import ccr_pkg::*;
(
  input  logic [1:0] st_in,
  input  logic       fz_en,
  input  logic       trig,
  output logic [1:0] st_out
);
  always_comb begin
    st_out = st_in;
    if (trig && fz_en && (st_in == CST_ON)) st_out = CST_FROZEN;
  end
endmodule

// File: rtl/ccr_flush.sv
module ccr_flush (
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  input  logic done,
  output logic req,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      pend <= 1'b0;
    end else begin
      req <= cmd;
      if (cmd)       pend <= 1'b1;
      else if (done) pend <= 1'b0;
    end
  end

  a_r7_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    req |=> !req || $past(cmd));
  a_r7_pend_with_req: assert property (@(posedge clk) disable iff (rst)
    req |-> pend);
  a_r8_done_clears: assert property (@(posedge clk) disable iff (rst)
    (done && !cmd) |=> !pend);
endmodule

// File: rtl/cache_ctl_reg.sv
module cache_ctl_reg
  import ccr_pkg::*;
#(
  parameter int              TRAP_W   = 8,
  parameter int              GRP_LSB  = 4,
  parameter logic [TRAP_W-1:0] EXT_BASE = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              irq_ack,
  input  logic [TRAP_W-1:0] irq_trap,
  input  logic              iflush_done,
  input  logic              dflush_done,
  output logic              ic_enable,
  output logic              ic_frozen,
  output logic              dc_enable,
  output logic              dc_frozen,
  output logic              ic_flush_req,
  output logic              dc_flush_req,
  output logic              ic_burst,
  output logic              dc_snoop
);
  localparam int GRP_W = TRAP_W - GRP_LSB;

  logic [NCACHE-1:0][1:0] st_q, st_base, st_n;
  logic [NCACHE-1:0]      fz_q, fz_base, done_v, req_v, pend_v;
  logic                   burst_q, snoop_q, ack_ext;
  logic [NCACHE-1:0]      en_q, frz_q;

  assign ack_ext = irq_ack &&
                   (irq_trap[TRAP_W-1:GRP_LSB] == EXT_BASE[TRAP_W-1:GRP_LSB]);
  assign done_v  = {dflush_done, iflush_done};

  for (genvar c = 0; c < NCACHE; c++) begin : g_cache
    assign st_base[c] = wr_en ? wr_data[2*c +: 2]   : st_q[c];
    assign fz_base[c] = wr_en ? wr_data[FZ_LSB + c] : fz_q[c];

    ccr_freeze u_frz (
      .st_in  (st_base[c]),
      .fz_en  (fz_base[c]),
      .trig   (ack_ext),
      .st_out (st_n[c])
    );

    ccr_flush u_fl (
      .clk  (clk),
      .rst  (rst),
      .cmd  (wr_en && wr_data[FLUSH_LSB + c]),
      .done (done_v[c]),
      .req  (req_v[c]),
      .pend (pend_v[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= '0;
      fz_q    <= '0;
      burst_q <= 1'b0;
      snoop_q <= 1'b0;
      en_q    <= '0;
      frz_q   <= '0;
    end else begin
      st_q <= st_n;
      fz_q <= fz_base;
      if (wr_en) begin
        burst_q <= wr_data[BURST_BIT];
        snoop_q <= wr_data[SNOOP_BIT];
      end
      for (int c = 0; c < NCACHE; c++) begin
        en_q[c]  <= (st_n[c] == CST_ON);
        frz_q[c] <= (st_n[c] == CST_FROZEN);
      end
    end
  end

  always_comb begin
    rd_data            = '0;
    rd_data[1:0]       = st_q[0];
    rd_data[3:2]       = st_q[1];
    rd_data[FZ_LSB]    = fz_q[0];
    rd_data[FZ_LSB+1]  = fz_q[1];
    rd_data[PEND_D]    = pend_v[1];
    rd_data[PEND_I]    = pend_v[0];
    rd_data[BURST_BIT] = burst_q;
    rd_data[SNOOP_BIT] = snoop_q;
  end

  assign ic_enable    = en_q[0];
  assign ic_frozen    = frz_q[0];
  assign dc_enable    = en_q[1];
  assign dc_frozen    = frz_q[1];
  assign ic_flush_req = req_v[0];
  assign dc_flush_req = req_v[1];
  assign ic_burst     = burst_q;
  assign dc_snoop     = snoop_q;

  a_r4_ifreeze: assert property (@(posedge clk) disable iff (rst)
    (ack_ext && !wr_en && fz_q[0] && st_q[0] == CST_ON) |=> st_q[0] == CST_FROZEN);
  a_r5_dstate_kept: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !wr_en && (st_q[1] != CST_ON || !fz_q[1])) |=> $stable(st_q[1]));
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!ack_ext && !wr_en) |=> $stable(st_q));
  a_r9_write_then_freeze: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ack_ext && wr_data[FZ_LSB+1] && wr_data[3:2] == 2'b11)
      |=> st_q[1] == CST_FROZEN);
  a_r3_decode_excl: assert property (@(posedge clk) disable iff (rst)
    !(ic_enable && ic_frozen) && !(dc_enable && dc_frozen));
endmodule

// File: tb/sim_cache_ctl_reg.sv
module sim_cache_ctl_reg;
  localparam int CLK_PER = 10;
  localparam logic [31:0] WMASK = 32'h0081_003F;

  logic        clk = 0, rst = 1, wr_en = 0, irq_ack = 0;
  logic        iflush_done = 0, dflush_done = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic [7:0]  irq_trap = '0;
  logic ic_enable, ic_frozen, dc_enable, dc_frozen;
  logic ic_flush_req, dc_flush_req, ic_burst, dc_snoop;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  cache_ctl_reg u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] frz(logic [1:0] st, logic en);
    return (en && st == 2'd3) ? 2'd1 : st;
  endfunction

  function automatic logic [3:0] dec(logic [1:0] i, logic [1:0] d);
    return {i == 2'd3, i == 2'd1, d == 2'd3, d == 2'd1};
  endfunction

  task automatic wr(logic [31:0] v);
    wr_en = 1; wr_data = v;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1
    chk("R1 rd_data", rd_data, 0);
    chk("R1 outputs", {ic_enable, ic_frozen, dc_enable, dc_frozen,
                       ic_flush_req, dc_flush_req, ic_burst, dc_snoop}, 0);
    // R2
    wr(32'hFF9F_FFFF);
    chk("R2 writable mask", rd_data, WMASK);
    chk("R2 burst/snoop", {ic_burst, dc_snoop}, 2'b11);
    // R3..R6, R9 sweep
    for (int s = 0; s < 16; s++)
      for (int f = 0; f < 4; f++)
        for (int ext = 0; ext < 2; ext++)
          for (int same = 0; same < 2; same++) begin
            logic [31:0] v;
            logic [1:0] ei, ed;
            v = 32'(s) | 32'(f << 4) | (32'(s & 1) << 16) | (32'((s >> 1) & 1) << 23);
            ei = 2'(s); ed = 2'(s >> 2);
            if (ext != 0) begin
              ei = frz(ei, f[0]); ed = frz(ed, f[1]);
            end
            if (same == 0) wr(v);
            irq_ack = 1;
            irq_trap = (ext != 0) ? 8'h10 + 8'(s) : ((s & 1) != 0 ? 8'h20 : 8'h0F);
            if (same != 0) begin wr_en = 1; wr_data = v; end
            @(negedge clk);
            irq_ack = 0; wr_en = 0; wr_data = '0;
            chk(same != 0 ? "R9 write+ack" : (ext != 0 ? "R4 R5 ext ack" : "R6 non-ext ack"),
                rd_data, (v & WMASK & ~32'hF) | {28'd0, ed, ei});
            @(negedge clk);
            chk("R3 decode", {28'd0, ic_enable, ic_frozen, dc_enable, dc_frozen},
                {28'd0, dec(ei, ed)});
          end
    // R7/R8 instruction flush
    wr(32'h0020_0000);
    chk("R7 iflush pulse", {30'd0, ic_flush_req, dc_flush_req}, 2);
    chk("R7 ipend set", rd_data, 32'h0000_8000);
    @(negedge clk);
    chk("R7 pulse one cycle", {30'd0, ic_flush_req, dc_flush_req}, 0);
    chk("R8 ipend held", rd_data, 32'h0000_8000);
    iflush_done = 1; @(negedge clk); iflush_done = 0;
    chk("R8 ipend cleared", rd_data, 0);
    // data flush
    wr(32'h0040_0000);
    chk("R7 dflush pulse", {30'd0, ic_flush_req, dc_flush_req}, 1);
    chk("R7 dpend set", rd_data, 32'h0000_4000);
    @(negedge clk);
    chk("R7 dpulse one cycle", {31'd0, dc_flush_req}, 0);
    wr(32'h0000_C000);
    chk("R8 pend write ignored", rd_data, 32'h0000_4000);
    dflush_done = 1; @(negedge clk); dflush_done = 0;
    chk("R8 dpend cleared", rd_data, 0);
    wr(32'h0000_C000);
    chk("R8 pend not settable", rd_data, 0);
    // both at once
    wr(32'hFFFF_FFFF);
    chk("R7 both pulses", {30'd0, ic_flush_req, dc_flush_req}, 3);
    chk("R2 R7 full readback", rd_data, WMASK | 32'h0000_C000);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule